// File: doc/BRIEF.md
# Serial programming instruction receiver

This block is the target end of an in-system programming link. A host drives a serial clock and a data line into the target, and reads a return data line back. It can also hold the target in programming reset through a separate pin. The receiver brings the three host pins into the system clock domain and finds the serial clock edges there. It assembles the incoming bits into fixed four-byte instructions and decodes them. Load, write and read requests go to a memory back end through a single request/acknowledge port. The block returns a response byte for every byte it receives.

The receiver starts disabled. The host enables it with the instruction `AC 53 xx xx`. While the third byte of any frame shifts in, the second byte comes back on the return line. A host that has slipped a bit therefore sees a wrong echo, and can pulse the reset pin to start again. The decoded commands take effect only once the receiver is enabled. The return line is driven only while it carries something meaningful.

Two state machines share the control logic. The frame-position machine has the states `POS_OPC`, `POS_AHI`, `POS_ALO` and `POS_DAT`. On each completed byte it moves `POS_OPC`→`POS_AHI`→`POS_ALO`→`POS_DAT`→`POS_OPC`, and it returns to `POS_OPC` from any state while the reset pin is high. The request machine has the states `RQ_IDLE` and `RQ_BUSY`. It goes `RQ_IDLE`→`RQ_BUSY` when a decoded command issues, and `RQ_BUSY`→`RQ_IDLE` on acknowledge.

Top module: `isp_cmd_rx`

## Requirements
- R1: Data is sampled on each rising serial clock edge, most significant bit first. Every 32 bits form one instruction with bytes at positions 0 to 3, and a stray bit shifts all later framing.
- R2: The return line `miso` changes only in the clock cycle after a detected falling serial clock edge, or when the reset pin clears it.
- R3: The block becomes enabled at the end of a frame whose byte 0 is 0xAC and byte 1 is 0x53. The same frame with any other byte 1 leaves it disabled.
- R4: Each response byte is the byte received just before it, except for read data. During byte 2 of every frame the host therefore reads back byte 1, which is 0x53 for an in-sync enable.
- R5: While disabled, no request is issued for any opcode. `miso_oe` is low except during bytes 1 to 3 of a frame whose byte 0 is 0xAC.
- R6: A high level on `tgt_rst` clears the bit counter, the frame position and the enabled state.
- R7: When enabled, opcodes 0x20, 0x28 and 0xA0 issue a read request after byte 2 with `req_kind` 3, 4 and 5 and `req_addr` = {byte1, byte2}. The acknowledged `rd_data` is shifted out MSB first during byte 3.
- R8: When enabled, opcodes 0x40, 0x48, 0x4C and 0xC0 issue a request after byte 3 with `req_kind` 0, 1, 2 and 6, `req_addr` = {byte1, byte2} and `req_data` = byte3.
- R9: Every other opcode, including 0xAC once enabled, issues no request.
- R10: `req_valid` stays high with stable kind, address and data until `req_ack`, then drops for at least one cycle. Each instruction yields at most one request.
- R11: While enabled, `miso_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tgt_rst | input | 1 | Programming reset pin, active high, asynchronous |
| sck | input | 1 | Serial clock from the host, asynchronous |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial response data to the host |
| miso_oe | output | 1 | Drive enable for the response line |
| req_valid | output | 1 | Memory request pending |
| req_kind | output | 3 | Request kind code (see R7, R8) |
| req_addr | output | 16 | Request address {byte1, byte2} |
| req_data | output | 8 | Write or load data (byte3) |
| req_ack | input | 1 | Back end accepts the request; read data valid |
| rd_data | input | 8 | Read data returned with `req_ack` |

## Verification
A serial clock edge is seen two to three system cycles after it happens. A completed byte takes effect in that same cycle. A request appears one cycle later, and `miso` moves one cycle after a falling edge is seen. Each serial half period lasts eight system clocks. The bench reads `miso` on its own rising serial edge, long after the previous fall has settled. It checks request fields and `miso_oe` several cycles after the frame's last edge. The back-end model acknowledges on the falling system clock edge, so read data is loaded well before the next falling serial edge.

// File: rtl/isp_pkg.sv
package isp_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] OP_ENABLE = 8'hAC;
    localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'h53;
    localparam logic [BYTE_W-1:0] OP_LD_LO  = 8'h40;
    localparam logic [BYTE_W-1:0] OP_LD_HI  = 8'h48;
    localparam logic [BYTE_W-1:0] OP_WR_PG  = 8'h4C;
    localparam logic [BYTE_W-1:0] OP_RD_LO  = 8'h20;
    localparam logic [BYTE_W-1:0] OP_RD_HI  = 8'h28;
    localparam logic [BYTE_W-1:0] OP_EE_RD  = 8'hA0;
    localparam logic [BYTE_W-1:0] OP_EE_WR  = 8'hC0;

    typedef enum logic [2:0] {
        K_LOAD_LO    = 3'd0,
        K_LOAD_HI    = 3'd1,
        K_WRITE_PAGE = 3'd2,
        K_READ_LO    = 3'd3,
        K_READ_HI    = 3'd4,
        K_EE_READ    = 3'd5,
        K_EE_WRITE   = 3'd6
    } req_kind_e;

    typedef enum logic [1:0] {
        POS_OPC = 2'd0,
        POS_AHI = 2'd1,
        POS_ALO = 2'd2,
        POS_DAT = 2'd3
    } frame_pos_e;

    typedef enum logic {
        RQ_IDLE = 1'b0,
        RQ_BUSY = 1'b1
    } req_state_e;

    typedef struct packed {
        logic      hit;
        logic      rd;
        req_kind_e kind;
    } op_dec_t;

    function automatic op_dec_t decode_op(input logic [BYTE_W-1:0] op);
        op_dec_t d;
        d = '{hit: 1'b1, rd: 1'b0, kind: K_LOAD_LO};
        case (op)
            OP_LD_LO: d.kind = K_LOAD_LO;
            OP_LD_HI: d.kind = K_LOAD_HI;
            OP_WR_PG: d.kind = K_WRITE_PAGE;
            OP_EE_WR: d.kind = K_EE_WRITE;
            OP_RD_LO: begin d.kind = K_READ_LO; d.rd = 1'b1; end
            OP_RD_HI: begin d.kind = K_READ_HI; d.rd = 1'b1; end
            OP_EE_RD: begin d.kind = K_EE_READ; d.rd = 1'b1; end
            default:  d.hit = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/isp_pin_sync.sv
module isp_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_a,
    input  logic mosi_a,
    input  logic hold_a,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s,
    output logic hold_s
);
    localparam int NPIN = 3;

    logic [NPIN-1:0] pins_a;
    logic [NPIN-1:0] pins_s;
    logic            sck_prev;

    assign pins_a = {hold_a, mosi_a, sck_a};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], pins_a[g]};
        end
        assign pins_s[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= pins_s[0];
    end

    assign sck_rise = pins_s[0] & ~sck_prev;
    assign sck_fall = ~pins_s[0] & sck_prev;
    assign mosi_s   = pins_s[1];
    assign hold_s   = pins_s[2];

endmodule

// File: rtl/isp_shifter.sv
module isp_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         rise,
    input  logic         fall,
    input  logic         din,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic         done,
    output logic [W-1:0] rx_byte,
    output logic         dout
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt;
    logic [W-1:0]  rx_sh;
    logic [W-1:0]  tx_sh;

    assign rx_byte = {rx_sh[W-2:0], din};
    assign done    = rise && !clr && (cnt == CW'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            rx_sh <= '0;
        end else if (clr) begin
            cnt   <= '0;
        end else if (rise) begin
            rx_sh <= rx_byte;
            cnt   <= done ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '1;
            dout  <= 1'b1;
        end else if (clr) begin
            tx_sh <= '1;
            dout  <= 1'b1;
        end else if (fall) begin
            dout  <= tx_sh[W-1];
            tx_sh <= {tx_sh[W-2:0], 1'b1};
        end else if (ld) begin
            tx_sh <= ld_val;
        end
    end

endmodule

// File: rtl/isp_frame_ctrl.sv
module isp_frame_ctrl
    import isp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              req_ack,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              ld,
    output logic [BYTE_W-1:0] ld_val,
    output logic              req_valid,
    output req_kind_e         req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic [BYTE_W-1:0] req_data,
    output logic              prog_en,
    output logic              echo_win
);
    frame_pos_e  pos_q, pos_d;
    req_state_e  rq_q, rq_d;
    logic [BYTE_W-1:0] op_q, ahi_q, alo_q;
    op_dec_t     dec;
    logic        issue_rd, issue_wr, pend_rd;

    assign dec      = decode_op(op_q);
    assign issue_rd = done && (pos_q == POS_ALO) && prog_en && dec.hit && dec.rd
                      && (rq_q == RQ_IDLE);
    assign issue_wr = done && (pos_q == POS_DAT) && prog_en && dec.hit && !dec.rd
                      && (rq_q == RQ_IDLE);
    assign pend_rd  = (req_kind == K_READ_LO) || (req_kind == K_READ_HI)
                      || (req_kind == K_EE_READ);

    // frame position and request state transitions
    always_comb begin
        pos_d = pos_q;
        if (hold) begin
            pos_d = POS_OPC;
        end else if (done) begin
            unique case (pos_q)
                POS_OPC: pos_d = POS_AHI;
                POS_AHI: pos_d = POS_ALO;
                POS_ALO: pos_d = POS_DAT;
                POS_DAT: pos_d = POS_OPC;
            endcase
        end
    end

    always_comb begin
        rq_d = rq_q;
        unique case (rq_q)
            RQ_IDLE: if (issue_rd || issue_wr) rq_d = RQ_BUSY;
            RQ_BUSY: if (req_ack)              rq_d = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= POS_OPC;
            rq_q  <= RQ_IDLE;
        end else begin
            pos_q <= pos_d;
            rq_q  <= rq_d;
        end
    end

    // captured bytes, mode flags and request fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            ahi_q    <= '0;
            alo_q    <= '0;
            prog_en  <= 1'b0;
            echo_win <= 1'b0;
            req_kind <= K_LOAD_LO;
            req_addr <= '0;
            req_data <= '0;
        end else begin
            if (hold) begin
                prog_en  <= 1'b0;
                echo_win <= 1'b0;
            end else if (done) begin
                unique case (pos_q)
                    POS_OPC: begin
                        op_q     <= rx_byte;
                        echo_win <= (rx_byte == OP_ENABLE);
                    end
                    POS_AHI: ahi_q <= rx_byte;
                    POS_ALO: alo_q <= rx_byte;
                    POS_DAT: begin
                        echo_win <= 1'b0;
                        if (op_q == OP_ENABLE && ahi_q == SYNC_BYTE) prog_en <= 1'b1;
                    end
                endcase
            end
            if (issue_rd) begin
                req_kind <= dec.kind;
                req_addr <= {ahi_q, rx_byte};
                req_data <= '0;
            end else if (issue_wr) begin
                req_kind <= dec.kind;
                req_addr <= {ahi_q, alo_q};
                req_data <= rx_byte;
            end
        end
    end

    assign req_valid = (rq_q == RQ_BUSY);
    assign ld        = done || (req_valid && req_ack && pend_rd);
    assign ld_val    = done ? rx_byte : rd_data;

endmodule

// File: rtl/isp_cmd_rx.sv
module isp_cmd_rx
    import isp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgt_rst,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic              req_valid,
    output logic [2:0]        req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic [BYTE_W-1:0] req_data,
    input  logic              req_ack,
    input  logic [BYTE_W-1:0] rd_data
);
    logic              sck_rise, sck_fall, mosi_s, hold_s;
    logic              done, ld, prog_en, echo_win;
    logic [BYTE_W-1:0] rx_byte, ld_val;
    req_kind_e         kind_e;

    isp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_a    (sck),
        .mosi_a   (mosi),
        .hold_a   (tgt_rst),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_s   (mosi_s),
        .hold_s   (hold_s)
    );

    isp_shifter #(.W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hold_s),
        .rise    (sck_rise),
        .fall    (sck_fall),
        .din     (mosi_s),
        .ld      (ld),
        .ld_val  (ld_val),
        .done    (done),
        .rx_byte (rx_byte),
        .dout    (miso)
    );

    isp_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold_s),
        .done      (done),
        .rx_byte   (rx_byte),
        .req_ack   (req_ack),
        .rd_data   (rd_data),
        .ld        (ld),
        .ld_val    (ld_val),
        .req_valid (req_valid),
        .req_kind  (kind_e),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .prog_en   (prog_en),
        .echo_win  (echo_win)
    );

    assign req_kind = kind_e;
    assign miso_oe  = prog_en | echo_win;

endmodule

// File: rtl/isp_cmd_rx_chk.sv
module isp_cmd_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hold,
    input logic        sck_fall,
    input logic        prog_en,
    input logic        miso,
    input logic        miso_oe,
    input logic        req_valid,
    input logic        req_ack,
    input logic [2:0]  req_kind,
    input logic [15:0] req_addr,
    input logic [7:0]  req_data
);
    // R2: response line moves only after a falling serial edge or a reset-pin clear
    a_r2_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !hold) |=> $stable(miso));

    // R5: a request can only start while the block is enabled
    a_r5_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(prog_en));

    // R6: reset pin drops enable and the drive enable
    a_r6_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!prog_en && !miso_oe));

    // R10: pending request keeps its fields
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_kind)
                                     && $stable(req_addr) && $stable(req_data)));

    // R10: acknowledge retires the request
    a_r10_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> !req_valid);

    // R8: only defined kind codes appear
    a_r8_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_kind != 3'd7));

endmodule

bind isp_cmd_rx isp_cmd_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold_s),
    .sck_fall  (sck_fall),
    .prog_en   (prog_en),
    .miso      (miso),
    .miso_oe   (miso_oe),
    .req_valid (req_valid),
    .req_ack   (req_ack),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_data  (req_data)
);

// File: tb/tb_isp_cmd_rx.sv
module tb_isp_cmd_rx;
    localparam int CLK_P = 10;
    localparam int HALF  = 8;
    localparam int WDOG  = 150000;

    logic clk = 1'b0;
    logic rst_n, tgt_rst, sck, mosi;
    logic miso, miso_oe, req_valid, req_ack;
    logic [2:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_data, rd_data;

    int n_vec = 0, n_err = 0;
    int rec_cnt = 0;
    logic [2:0]  rec_kind;
    logic [15:0] rec_addr;
    logic [7:0]  rec_data;
    int ack_delay = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    isp_cmd_rx dut (
        .clk(clk), .rst_n(rst_n), .tgt_rst(tgt_rst), .sck(sck), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_data(req_data), .req_ack(req_ack), .rd_data(rd_data)
    );

    function automatic logic [7:0] rd_model(input logic [2:0] k, input logic [15:0] a);
        return (a[7:0] + 8'(k) * 8'h35) ^ a[15:8];
    endfunction

    function automatic int exp_kind(input logic [7:0] op);
        case (op)
            8'h40: return 0;
            8'h48: return 1;
            8'h4C: return 2;
            8'h20: return 3;
            8'h28: return 4;
            8'hA0: return 5;
            8'hC0: return 6;
            default: return -1;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // back-end model: acknowledges on the falling system clock edge
    initial begin
        int waited;
        waited = 0;
        req_ack = 1'b0;
        rd_data = 8'h00;
        forever begin
            @(negedge clk);
            if (req_valid === 1'b1 && !req_ack) begin
                if (waited < ack_delay) begin
                    waited++;
                end else begin
                    waited   = 0;
                    req_ack  = 1'b1;
                    rd_data  = rd_model(req_kind, req_addr);
                    rec_cnt++;
                    rec_kind = req_kind;
                    rec_addr = req_addr;
                    rec_data = req_data;
                end
            end else begin
                req_ack = 1'b0;
            end
        end
    end

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            mosi = b[i];
            repeat (HALF) @(negedge clk);
            sck  = 1'b1;
            r[i] = miso;
            repeat (HALF) @(negedge clk);
            sck  = 1'b0;
        end
    endtask

    task automatic frame(input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input logic [7:0] b3,
                         output logic [7:0] r2, output logic [7:0] r3);
        logic [7:0] rx;
        xfer(b0, rx);
        xfer(b1, rx);
        xfer(b2, r2);
        xfer(b3, r3);
        repeat (6) @(negedge clk);
    endtask

    task automatic stray_bits(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mosi = 1'b0;
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic pulse_tgt();
        @(negedge clk);
        tgt_rst = 1'b1;
        repeat (6) @(negedge clk);
        tgt_rst = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        logic [7:0] r2, r3, op, a1, a2, dd;
        int c0, k;
        sck = 1'b0; mosi = 1'b0; tgt_rst = 1'b0; rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R5 reset miso_oe", miso_oe, 0);
        chk("R10 reset req_valid", req_valid, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R5: commands ignored while disabled
        c0 = rec_cnt;
        frame(8'h20, 8'h12, 8'h34, 8'h00, r2, r3);
        chk("R5 no request while disabled", rec_cnt, c0);
        chk("R5 miso_oe low while disabled", miso_oe, 0);
        c0 = rec_cnt;
        frame(8'h40, 8'h00, 8'h01, 8'h5A, r2, r3);
        chk("R5 no load while disabled", rec_cnt, c0);

        // R3 R4: enable with a wrong second byte
        frame(8'hAC, 8'h52, 8'h00, 8'h00, r2, r3);
        chk("R4 echo of wrong sync byte", r2, 8'h52);
        chk("R3 wrong sync stays disabled", miso_oe, 0);

        // R1: a stray bit misaligns the frame so enable fails
        stray_bits(4);
        frame(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
        chk("R1 misaligned enable rejected", miso_oe, 0);

        // R6: reset pin realigns, then enable succeeds
        pulse_tgt();
        frame(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
        chk("R4 sync echo 0x53", r2, 8'h53);
        chk("R3 enabled after good frame", miso_oe, 1);

        // R6: reset pin drops enable
        pulse_tgt();
        chk("R6 reset pin clears enable", miso_oe, 0);
        c0 = rec_cnt;
        frame(8'h20, 8'h01, 8'h02, 8'h00, r2, r3);
        chk("R6 no request after reset pin", rec_cnt, c0);
        frame(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
        chk("R11 re-enabled", miso_oe, 1);

        // opcode sweep: every multiple of four
        for (int i = 0; i < 64; i++) begin
            op = 8'(i * 4);
            a1 = 8'(i * 37 + 5);
            a2 = 8'(i * 11 + 9);
            dd = 8'(i * 29 + 3);
            c0 = rec_cnt;
            frame(op, a1, a2, dd, r2, r3);
            k = exp_kind(op);
            if (k < 0) begin
                chk("R9 no request for other opcode", rec_cnt, c0);
            end else begin
                chk("R7 R8 one request", rec_cnt, c0 + 1);
                chk("R7 R8 request kind", rec_kind, k);
                chk("R7 R8 request address", rec_addr, {a1, a2});
                if (k >= 3 && k <= 5)
                    chk("R7 R2 read data on miso", r3, rd_model(3'(k), {a1, a2}));
                else
                    chk("R8 request data", rec_data, dd);
            end
            chk("R4 echo of second byte", r2, a1);
            chk("R11 miso_oe while enabled", miso_oe, 1);
        end

        // R10: slow acknowledge still yields one request with held fields
        ack_delay = 6;
        c0 = rec_cnt;
        frame(8'hC0, 8'h3E, 8'h71, 8'hA5, r2, r3);
        repeat (10) @(negedge clk);
        chk("R10 single request on slow ack", rec_cnt, c0 + 1);
        chk("R10 held address", rec_addr, 16'h3E71);
        chk("R10 held data", rec_data, 8'hA5);
        chk("R10 request retired", req_valid, 0);
        ack_delay = 0;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_err++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", WDOG, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

endmodule